// File: doc/BRIEF.md
# Glitch-Free Output Clock Stop Controller

This block sits between the clock sources of a clock-generator chip and its output pads. It gates four groups of clocks: a CPU group, a PCI group, a memory group and one free-running PCI clock that also serves as the timing reference. Each output is started and stopped so that no shortened high pulse ever reaches a pad. Whether an output runs is decided by a per-output register enable bit, by two active-low stop pins (CPU and PCI) and by a pin-mode input that selects whether those two pins act as stop requests at all. When the pin mode selects stop pins, the last two memory outputs are unused and stay low. When it does not, the stop pins are ignored and those two memory outputs are driven.

Every start or stop request passes through a two-flop synchronizer in the reference domain. It is then latched on a rising reference edge, and finally taken by a per-output enable flop on the next falling edge of the clock being gated. Each gate is therefore a plain AND that only changes its enable while its source is low. A power-down input forces every output low at once. When power-down is released, gating stays closed for a parameterized settle window, which by default is about 0.2 ms of reference cycles. A two-bit output-mode field drives a pad output-enable that is low only in the high-impedance setting.

Top module: `clock_stop_ctrl`

## Requirements
- R1: After reset every clock output is low, and it stays low for at least SETTLE_CYCLES rising edges of the reference clock.
- R2: Once settled, each output runs exactly when its own register enable bit is 1 and no stop condition applies to it. An output whose bit is 0 is held low. Output groups are individually controllable.
- R3: A change of any request (enable bit, stop pin, pin mode) does not show at the output before the third rising reference edge after the change. It has taken effect by the fourth rising edge. Every high pulse that reaches an output lasts the full high phase of its source.
- R4: With the pin mode low (0) and the CPU stop pin low, all CPU outputs are held low. PCI, free-running and memory outputs 0..N_MEM-3 keep running.
- R5: With the pin mode low and the PCI stop pin low, all PCI group outputs are held low. The CPU outputs and the free-running PCI output keep running.
- R6: With the pin mode high (1), both stop pins have no effect, and the two top memory outputs (indices N_MEM-2 and N_MEM-1) follow only their enable bits. With the pin mode low, those two memory outputs are held low.
- R7: The free-running PCI output is unaffected by the PCI stop pin and stops only through its own enable bit or power-down.
- R8: While power-down (active low) is asserted, every output, including the free-running PCI output, is low, starting in the same cycle.
- R9: After power-down is released, all outputs stay low for at least SETTLE_CYCLES reference cycles and then resume according to their enables.
- R10: The output enable is 1 for output-mode codes 00 (normal), 01 (test) and 10 (reserved, same as normal), and 0 for code 11 (high impedance). The code does not alter the gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, reference domain |
| ref_clk_i | input | 1 | PCI-rate source clock, also the timing reference |
| cpu_clk_i | input | 1 | CPU-rate source clock |
| mem_clk_i | input | 1 | Memory-rate source clock |
| cpu_en_i | input | N_CPU | Register enable bits of the CPU outputs |
| pci_en_i | input | N_PCI | Register enable bits of the PCI outputs |
| pcif_en_i | input | 1 | Register enable bit of the free-running PCI output |
| mem_en_i | input | N_MEM | Register enable bits of the memory outputs |
| cpu_stop_n_i | input | 1 | CPU stop request, active low, used only in pin mode 0 |
| pci_stop_n_i | input | 1 | PCI stop request, active low, used only in pin mode 0 |
| pin_mode_i | input | 1 | 0: stop pins active; 1: stop pins ignored, top two memory outputs used |
| pwrdn_n_i | input | 1 | Power-down, active low |
| out_mode_i | input | 2 | Output mode: 00 normal, 01 test, 10 reserved, 11 high impedance |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pcif_clk_o | output | 1 | Gated free-running PCI clock |
| mem_clk_o | output | N_MEM | Gated memory clocks |
| oe_o | output | 1 | Pad output enable |

## Verification
Within a single reference cycle, the CPU stop pin can be released while the PCI stop pin is asserted. One group then starts as the other stops, and both travel the same synchronizer and arming path in the same cycles. The bench drives both pins at one instant and, in one observation window, expects the CPU group running and the PCI group silent, with the free-running output untouched. Monitors on representative outputs count any high pulse shorter than its source high phase across these overlapping transitions. A switch of the pin mode made while both stop pins are low likewise checks that the stops vanish and the top memory outputs appear in the same window.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock stop controller.
// Assumes: output-mode field is two bits wide.
package csc_pkg;
    typedef enum logic [1:0] {
        OMODE_RUN  = 2'b00,
        OMODE_TEST = 2'b01,
        OMODE_RSVD = 2'b10,
        OMODE_HIZ  = 2'b11
    } out_mode_e;

    // True when the field selects high impedance on all pads.
    function automatic logic is_hiz(input logic [1:0] code);
        return out_mode_e'(code) == OMODE_HIZ;
    endfunction
endpackage

// File: rtl/csc_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank into the reference domain.
// Assumes: each bit is an independent level; reset value is all zeros.
module csc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/csc_policy.sv
`timescale 1ns/1ps
// Enable policy and settle timer in the reference domain.
// Combines synchronized enable bits, stop pins and pin mode into one arm
// request per output, registered on the rising reference edge. Holds all
// arms low until SETTLE_CYCLES cycles have passed with power present.
// Assumes: all inputs are already synchronized to clk.
module csc_policy #(
    parameter int N_CPU         = 4,
    parameter int N_PCI         = 6,
    parameter int N_MEM         = 8,
    parameter int N_SHARED      = 2,
    parameter int SETTLE_CYCLES = 6667
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CPU-1:0] cpu_en_s,
    input  logic [N_PCI-1:0] pci_en_s,
    input  logic             pcif_en_s,
    input  logic [N_MEM-1:0] mem_en_s,
    input  logic             cpu_stop_n_s,
    input  logic             pci_stop_n_s,
    input  logic             pin_mode_s,
    input  logic             pwr_s,
    output logic [N_CPU-1:0] arm_cpu_o,
    output logic [N_PCI-1:0] arm_pci_o,
    output logic             arm_pcif_o,
    output logic [N_MEM-1:0] arm_mem_o
);
    localparam int CW         = $clog2(SETTLE_CYCLES + 1);
    localparam int FIRST_SHR  = N_MEM - N_SHARED;

    logic [CW-1:0]    settle_cnt;
    logic             settled_q;
    logic             cpu_go;
    logic             pci_go;
    logic [N_MEM-1:0] mem_req;

    // Stop pins count only while the pin mode selects them.
    assign cpu_go = pin_mode_s | cpu_stop_n_s;
    assign pci_go = pin_mode_s | pci_stop_n_s;

    // Shared memory outputs exist only in pin mode 1.
    for (genvar gi = 0; gi < N_MEM; gi++) begin : g_mem_req
        if (gi >= FIRST_SHR) begin : g_shared
            assign mem_req[gi] = mem_en_s[gi] & pin_mode_s;
        end else begin : g_plain
            assign mem_req[gi] = mem_en_s[gi];
        end
    end

    // Settle timer: restarts on reset or power loss, then counts up once.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_s) begin
            settle_cnt <= '0;
            settled_q  <= 1'b0;
        end else if (!settled_q) begin
            if (settle_cnt == CW'(SETTLE_CYCLES - 1)) begin
                settled_q <= 1'b1;
            end else begin
                settle_cnt <= settle_cnt + 1'b1;
            end
        end
    end

    // Arm register: the rising reference edge that precedes each gate change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_cpu_o  <= '0;
            arm_pci_o  <= '0;
            arm_pcif_o <= 1'b0;
            arm_mem_o  <= '0;
        end else begin
            arm_cpu_o  <= cpu_en_s & {N_CPU{cpu_go & settled_q & pwr_s}};
            arm_pci_o  <= pci_en_s & {N_PCI{pci_go & settled_q & pwr_s}};
            arm_pcif_o <= pcif_en_s & settled_q & pwr_s;
            arm_mem_o  <= mem_req & {N_MEM{settled_q & pwr_s}};
        end
    end
endmodule

// File: rtl/csc_gate.sv
`timescale 1ns/1ps
// Glitch-free gate for one clock output.
// The enable flop updates only on the falling edge of its own source, so
// the AND never cuts a high phase. Power loss forces the output low at once.
// Assumes: arm_i is stable around the source falling edge.
module csc_gate (
    input  logic src_clk_i,
    input  logic rst_n,
    input  logic arm_i,
    input  logic pwr_ok_i,
    output logic clk_o
);
    logic en_q;

    // Take the arm request while the source is low.
    always_ff @(negedge src_clk_i) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= arm_i;
        end
    end

    assign clk_o = src_clk_i & en_q & pwr_ok_i;
endmodule

// File: rtl/clock_stop_ctrl.sv
`timescale 1ns/1ps
// Clock stop controller top.
// Synchronizes all control levels into the reference domain, applies the
// enable policy and drives one glitch-free gate per output.
// Assumes: ref_clk_i is the source of the PCI and free-running outputs;
// rst_n is synchronous to ref_clk_i.
module clock_stop_ctrl #(
    parameter int N_CPU         = 4,
    parameter int N_PCI         = 6,
    parameter int N_MEM         = 8,
    parameter int N_SHARED      = 2,
    parameter int SETTLE_CYCLES = 6667
) (
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             cpu_clk_i,
    input  logic             mem_clk_i,
    input  logic [N_CPU-1:0] cpu_en_i,
    input  logic [N_PCI-1:0] pci_en_i,
    input  logic             pcif_en_i,
    input  logic [N_MEM-1:0] mem_en_i,
    input  logic             cpu_stop_n_i,
    input  logic             pci_stop_n_i,
    input  logic             pin_mode_i,
    input  logic             pwrdn_n_i,
    input  logic [1:0]       out_mode_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pcif_clk_o,
    output logic [N_MEM-1:0] mem_clk_o,
    output logic             oe_o
);
    import csc_pkg::*;

    localparam int SW = N_CPU + N_PCI + 1 + N_MEM + 4;

    logic [SW-1:0]    raw_bus;
    logic [SW-1:0]    syn_bus;
    logic [N_CPU-1:0] cpu_en_s;
    logic [N_PCI-1:0] pci_en_s;
    logic             pcif_en_s;
    logic [N_MEM-1:0] mem_en_s;
    logic             cpu_stop_n_s;
    logic             pci_stop_n_s;
    logic             pin_mode_s;
    logic             pwr_s;
    logic [N_CPU-1:0] arm_cpu;
    logic [N_PCI-1:0] arm_pci;
    logic             arm_pcif;
    logic [N_MEM-1:0] arm_mem;

    assign raw_bus = {cpu_en_i, pci_en_i, pcif_en_i, mem_en_i,
                      cpu_stop_n_i, pci_stop_n_i, pin_mode_i, pwrdn_n_i};

    csc_sync #(.W(SW)) i_sync (
        .clk   (ref_clk_i),
        .rst_n (rst_n),
        .d_i   (raw_bus),
        .q_o   (syn_bus)
    );

    assign {cpu_en_s, pci_en_s, pcif_en_s, mem_en_s,
            cpu_stop_n_s, pci_stop_n_s, pin_mode_s, pwr_s} = syn_bus;

    csc_policy #(
        .N_CPU         (N_CPU),
        .N_PCI         (N_PCI),
        .N_MEM         (N_MEM),
        .N_SHARED      (N_SHARED),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) i_policy (
        .clk          (ref_clk_i),
        .rst_n        (rst_n),
        .cpu_en_s     (cpu_en_s),
        .pci_en_s     (pci_en_s),
        .pcif_en_s    (pcif_en_s),
        .mem_en_s     (mem_en_s),
        .cpu_stop_n_s (cpu_stop_n_s),
        .pci_stop_n_s (pci_stop_n_s),
        .pin_mode_s   (pin_mode_s),
        .pwr_s        (pwr_s),
        .arm_cpu_o    (arm_cpu),
        .arm_pci_o    (arm_pci),
        .arm_pcif_o   (arm_pcif),
        .arm_mem_o    (arm_mem)
    );

    // One gate per CPU output.
    for (genvar gi = 0; gi < N_CPU; gi++) begin : g_cpu
        csc_gate i_gate (
            .src_clk_i (cpu_clk_i), .rst_n (rst_n), .arm_i (arm_cpu[gi]),
            .pwr_ok_i  (pwrdn_n_i), .clk_o (cpu_clk_o[gi])
        );
    end

    // One gate per PCI output.
    for (genvar gi = 0; gi < N_PCI; gi++) begin : g_pci
        csc_gate i_gate (
            .src_clk_i (ref_clk_i), .rst_n (rst_n), .arm_i (arm_pci[gi]),
            .pwr_ok_i  (pwrdn_n_i), .clk_o (pci_clk_o[gi])
        );
    end

    // One gate per memory output.
    for (genvar gi = 0; gi < N_MEM; gi++) begin : g_mem
        csc_gate i_gate (
            .src_clk_i (mem_clk_i), .rst_n (rst_n), .arm_i (arm_mem[gi]),
            .pwr_ok_i  (pwrdn_n_i), .clk_o (mem_clk_o[gi])
        );
    end

    csc_gate i_gate_pcif (
        .src_clk_i (ref_clk_i), .rst_n (rst_n), .arm_i (arm_pcif),
        .pwr_ok_i  (pwrdn_n_i), .clk_o (pcif_clk_o)
    );

    assign oe_o = !is_hiz(out_mode_i);
endmodule

// File: rtl/clock_stop_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for clock_stop_ctrl, attached with bind.
// Assumes: stop, mode and power-down levels are held for at least three
// reference cycles; outputs are sampled in the high phase of their source.
module clock_stop_ctrl_chk #(
    parameter int N_CPU         = 4,
    parameter int N_PCI         = 6,
    parameter int N_MEM         = 8,
    parameter int N_SHARED      = 2,
    parameter int SETTLE_CYCLES = 6667
) (
    input logic             rst_n,
    input logic             ref_clk_i,
    input logic             cpu_clk_i,
    input logic             mem_clk_i,
    input logic             cpu_stop_n_i,
    input logic             pci_stop_n_i,
    input logic             pin_mode_i,
    input logic             pwrdn_n_i,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_PCI-1:0] pci_clk_o,
    input logic             pcif_clk_o,
    input logic [N_MEM-1:0] mem_clk_o
);
    logic [7:0]  cpu_hold;
    logic [7:0]  pci_hold;
    logic [7:0]  pin_low_hold;
    logic [31:0] up_cnt;

    // Saturating counts of reference cycles each condition has persisted.
    always_ff @(posedge ref_clk_i) begin
        if (!rst_n) begin
            cpu_hold     <= '0;
            pci_hold     <= '0;
            pin_low_hold <= '0;
            up_cnt       <= '0;
        end else begin
            cpu_hold     <= (!cpu_stop_n_i && !pin_mode_i) ?
                            ((cpu_hold == 8'hFF) ? cpu_hold : cpu_hold + 8'd1) : 8'd0;
            pci_hold     <= (!pci_stop_n_i && !pin_mode_i) ?
                            ((pci_hold == 8'hFF) ? pci_hold : pci_hold + 8'd1) : 8'd0;
            pin_low_hold <= !pin_mode_i ?
                            ((pin_low_hold == 8'hFF) ? pin_low_hold : pin_low_hold + 8'd1) : 8'd0;
            up_cnt       <= !pwrdn_n_i ? 32'd0 :
                            ((up_cnt == 32'hFFFF_FFFF) ? up_cnt : up_cnt + 32'd1);
        end
    end

    AST_PWRDN_ALL_LOW: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        !pwrdn_n_i |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pcif_clk_o && mem_clk_o == '0)); // R8

    AST_CPU_STOP_LOW: assert property (@(negedge cpu_clk_i) disable iff (!rst_n)
        (cpu_hold >= 8'd4) |-> (cpu_clk_o == '0)); // R4

    AST_PCI_STOP_LOW: assert property (@(negedge ref_clk_i) disable iff (!rst_n)
        (pci_hold >= 8'd4) |-> (pci_clk_o == '0)); // R5

    AST_SHARED_MEM_LOW: assert property (@(negedge mem_clk_i) disable iff (!rst_n)
        (pin_low_hold >= 8'd4) |-> (mem_clk_o[N_MEM-1 -: N_SHARED] == '0)); // R6

    AST_SETTLE_QUIET: assert property (@(negedge ref_clk_i) disable iff (!rst_n)
        (up_cnt <= 32'(SETTLE_CYCLES + 2)) |-> (pci_clk_o == '0 && !pcif_clk_o)); // R9
endmodule

bind clock_stop_ctrl clock_stop_ctrl_chk #(
    .N_CPU         (N_CPU),
    .N_PCI         (N_PCI),
    .N_MEM         (N_MEM),
    .N_SHARED      (N_SHARED),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) i_chk (
    .rst_n        (rst_n),
    .ref_clk_i    (ref_clk_i),
    .cpu_clk_i    (cpu_clk_i),
    .mem_clk_i    (mem_clk_i),
    .cpu_stop_n_i (cpu_stop_n_i),
    .pci_stop_n_i (pci_stop_n_i),
    .pin_mode_i   (pin_mode_i),
    .pwrdn_n_i    (pwrdn_n_i),
    .cpu_clk_o    (cpu_clk_o),
    .pci_clk_o    (pci_clk_o),
    .pcif_clk_o   (pcif_clk_o),
    .mem_clk_o    (mem_clk_o)
);

// File: tb/test_clock_stop_ctrl.sv
`timescale 1ns/1ps
module test_clock_stop_ctrl;
    localparam int SETTLE = 20;
    localparam logic [18:0] ALL   = 19'h7FFFF;
    localparam logic [18:0] CPU_M = 19'h0000F;
    localparam logic [18:0] PCI_M = 19'h003F0;
    localparam logic [18:0] PCF_M = 19'h00400;
    localparam logic [18:0] SHR_M = 19'h60000;
    localparam logic [18:0] M7_M  = 19'h40000;

    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       cpu_clk = 1'b0;
    logic       mem_clk = 1'b0;
    logic [3:0] cpu_en = '1;
    logic [5:0] pci_en = '1;
    logic       pcif_en = 1'b1;
    logic [7:0] mem_en = '1;
    logic       cpu_stop_n = 1'b1;
    logic       pci_stop_n = 1'b1;
    logic       pin_mode = 1'b1;
    logic       pwrdn_n = 1'b1;
    logic [1:0] out_mode = 2'b00;
    logic [3:0] cpu_o;
    logic [5:0] pci_o;
    logic       pcif_o;
    logic [7:0] mem_o;
    logic       oe;

    int checks = 0;
    int errors = 0;
    int runts  = 0;
    logic [18:0] act;
    real rise_c = 0.0, rise_p = 0.0, rise_f = 0.0;

    clock_stop_ctrl #(.SETTLE_CYCLES(SETTLE)) i_clock_stop_ctrl (
        .rst_n(rst_n), .ref_clk_i(ref_clk), .cpu_clk_i(cpu_clk), .mem_clk_i(mem_clk),
        .cpu_en_i(cpu_en), .pci_en_i(pci_en), .pcif_en_i(pcif_en), .mem_en_i(mem_en),
        .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n), .pin_mode_i(pin_mode),
        .pwrdn_n_i(pwrdn_n), .out_mode_i(out_mode),
        .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pcif_clk_o(pcif_o), .mem_clk_o(mem_o),
        .oe_o(oe)
    );

    // 100 MHz reference; CPU and memory sources at twice that, rising with it.
    initial forever #5 ref_clk = ~ref_clk;
    initial begin #2.5; forever #2.5 cpu_clk = ~cpu_clk; end
    initial begin #2.5; forever #2.5 mem_clk = ~mem_clk; end

    // Short-pulse monitors (R3); a power-down cut is exempt.
    always @(posedge cpu_o[0]) rise_c = $realtime;
    always @(negedge cpu_o[0]) if (pwrdn_n && rise_c > 0.0 && ($realtime - rise_c) < 2.4) runts++;
    always @(posedge pci_o[0]) rise_p = $realtime;
    always @(negedge pci_o[0]) if (pwrdn_n && rise_p > 0.0 && ($realtime - rise_p) < 4.9) runts++;
    always @(posedge pcif_o) rise_f = $realtime;
    always @(negedge pcif_o) if (pwrdn_n && rise_f > 0.0 && ($realtime - rise_f) < 4.9) runts++;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Safe instant to change inputs: away from every source edge.
    task automatic drive_point();
        @(negedge ref_clk);
        #1.25;
    endtask

    // OR of all outputs sampled mid-phase over n reference cycles.
    task automatic observe(input int n);
        act = '0;
        @(posedge ref_clk);
        #1.25;
        for (int k = 0; k < 4 * n; k++) begin
            act = act | {mem_o, pcif_o, pci_o, cpu_o};
            #2.5;
        end
    endtask

    task automatic settle_wait();
        repeat (4) @(posedge ref_clk);
    endtask

    task automatic t_reset();
        repeat (5) @(posedge ref_clk);
        drive_point();
        rst_n = 1'b1;
        observe(10);
        check("R1 quiet after reset", act, 19'h0);
        repeat (SETTLE) @(posedge ref_clk);
        observe(2);
        check("R2 all running", act, ALL);
    endtask

    task automatic t_individual();
        drive_point();
        cpu_en = 4'b0101; pci_en = 6'b100110; mem_en = 8'h3C;
        settle_wait();
        observe(2);
        check("R2 per-output enables", act, {8'h3C, 1'b1, 6'b100110, 4'b0101});
        drive_point();
        cpu_en = '1; pci_en = '1; mem_en = '1;
        settle_wait();
    endtask

    task automatic t_latency();
        drive_point();
        cpu_en[1] = 1'b0;
        observe(2);
        check("R3 stop not before third edge", act & 19'h2, 19'h2);
        observe(2);
        check("R3 stopped by fourth edge", act & 19'h2, 19'h0);
        drive_point();
        cpu_en[1] = 1'b1;
        observe(2);
        check("R3 start not before third edge", act & 19'h2, 19'h0);
        observe(2);
        check("R3 started by fourth edge", act & 19'h2, 19'h2);
    endtask

    task automatic t_cpu_stop();
        drive_point();
        pin_mode = 1'b0; cpu_stop_n = 1'b0;
        settle_wait();
        observe(2);
        check("R4 cpu stop", act, ALL & ~CPU_M & ~SHR_M);
    endtask

    // CPU group restarts while PCI group stops in the same cycle.
    task automatic t_pci_stop();
        drive_point();
        cpu_stop_n = 1'b1; pci_stop_n = 1'b0;
        settle_wait();
        observe(2);
        check("R5 pci stop, free-running kept", act, ALL & ~PCI_M & ~SHR_M);
        check("R6 shared memory low in pin mode 0", act & SHR_M, 19'h0);
    endtask

    task automatic t_pin_mode();
        drive_point();
        cpu_stop_n = 1'b0;
        pin_mode = 1'b1;
        settle_wait();
        observe(2);
        check("R6 stops ignored in pin mode 1", act, ALL);
        drive_point();
        mem_en[7] = 1'b0;
        settle_wait();
        observe(2);
        check("R6 shared output follows bit", act, ALL & ~M7_M);
        drive_point();
        mem_en[7] = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        settle_wait();
    endtask

    task automatic t_pcif();
        drive_point();
        pin_mode = 1'b0; pci_stop_n = 1'b0; pcif_en = 1'b0;
        settle_wait();
        observe(2);
        check("R7 free-running stops by own bit", act & PCF_M, 19'h0);
        drive_point();
        pcif_en = 1'b1;
        settle_wait();
        observe(2);
        check("R7 free-running ignores pci stop", act & PCF_M, PCF_M);
        drive_point();
        pin_mode = 1'b1; pci_stop_n = 1'b1;
        settle_wait();
    endtask

    task automatic t_power();
        drive_point();
        pwrdn_n = 1'b0;
        #0.5;
        check("R8 immediate low", {13'h0, mem_o, pcif_o, pci_o, cpu_o}, 32'h0);
        observe(1);
        check("R8 all low in power-down", act, 19'h0);
        repeat (4) @(posedge ref_clk);
        drive_point();
        pwrdn_n = 1'b1;
        observe(10);
        check("R9 quiet during settle", act, 19'h0);
        repeat (SETTLE) @(posedge ref_clk);
        observe(2);
        check("R9 resumed after settle", act, ALL);
    endtask

    task automatic t_out_mode();
        for (int c = 0; c < 4; c++) begin
            drive_point();
            out_mode = 2'(c);
            #1;
            check($sformatf("R10 oe for code %0d", c), {31'h0, oe}, (c == 3) ? 32'h0 : 32'h1);
        end
        observe(1);
        check("R10 gating unchanged in high impedance", act, ALL);
        drive_point();
        out_mode = 2'b00;
    endtask

    initial begin
        t_reset();
        t_individual();
        t_latency();
        t_cpu_stop();
        t_pci_stop();
        t_pin_mode();
        t_pcif();
        t_power();
        t_out_mode();
        check("R3 no short pulses", runts, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule